// File: doc/BRIEF.md
# Address-Window Abort Guard

This block watches every bus cycle of a 24-bit processor bus and compares the address against a small set of programmable windows. Each window has an inclusive lower and upper address bound, an enable, and separate read, write and execute permissions. When a cycle lands in an enabled window that does not grant the kind of access being made, the block raises a single-cycle abort request. The processor uses this request to cancel the offending instruction without changing any of its registers.

Each cycle is sorted by two cycle-type inputs, one marking a program-space access and one marking a data-space access. Opcode fetches need execute permission, writes need write permission, and all other qualified cycles need read permission. Cycles with neither input set are internal or false reads, and they are ignored. A build option can check false reads in emulation mode, where they are real bus reads that some peripherals depend on. After an abort, checking stays off until the processor signals its vector fetch for the abort service. This keeps the service sequence itself from being aborted. Each abort records the faulting address and cycle type in a status register that software reads and clears through the configuration port.

Top module: `addr_abort_guard`

## Requirements
- R1: After reset, abort_req is low, the fault info register reads 0, and every window is disabled, so no access aborts.
- R2: An access that falls inside an enabled window, with both bounds inclusive, and lacks the needed permission drives abort_req high in the cycle after the access.
- R3: A cycle with pgm_valid=1 and dat_valid=1 is an opcode fetch and needs only the execute bit (control bit 3).
- R4: A qualified cycle with rw_n=0 is a write and needs only the write bit (control bit 2).
- R5: A qualified read (rw_n=1, cycle type 01 or 10 as {pgm_valid,dat_valid}) needs only the read bit (control bit 1).
- R6: An address outside every enabled window never aborts. A window whose enable (control bit 0) is 0 has no effect.
- R7: When windows overlap, the lowest-numbered window that contains the address alone decides the outcome.
- R8: A cycle with pgm_valid=0 and dat_valid=0 never aborts, apart from the case in R9.
- R9: With EMU_FALSE_RD_CHECK=1, a cycle of type 00 with emu_mode=1 and rw_n=1 is checked as a read. With emu_mode=0, the same cycle is ignored.
- R10: abort_req is never high for two cycles in a row. After an abort, no further abort is raised until vec_pull has been sampled high, and checking resumes after that.
- R11: Each abort loads the access address into the status address register (index 4*NREGIONS). It also sets the fault info register (index 4*NREGIONS+1) to bit3=rw_n, bit2=pgm_valid, bit1=dat_valid and bit0=1.
- R12: Window i uses index 4*i for its lower bound, 4*i+1 for its upper bound and 4*i+2 for its control bits. Index 4*i+3 reads 0. All window registers read back as written. Writing 1 to bit 0 of the info register clears its valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Address of the current bus cycle |
| rw_n | input | 1 | 1 = read, 0 = write |
| pgm_valid | input | 1 | Program-space cycle marker |
| dat_valid | input | 1 | Data-space cycle marker |
| emu_mode | input | 1 | Processor emulation-mode flag |
| vec_pull | input | 1 | Vector fetch of the abort service is under way |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Configuration register index |
| cfg_wdata | input | DATA_W | Configuration write data |
| cfg_rdata | output | DATA_W | Configuration read data (combinational from cfg_sel) |
| abort_req | output | 1 | One-cycle abort request, active high |

## Verification
The bench builds the guard with four windows and EMU_FALSE_RD_CHECK=1. This setting brings the emulation-mode false-read path within reach, so the same type-00 read can be shown to abort with emu_mode high and to pass with it low. Four windows allow one read-only window, one fully open window, an overlapping window for the priority rule, and one window that is first disabled and then enabled with no permissions. Accesses exactly at the lower and upper bounds, and one address just outside them, exercise the inclusive compare.

// File: rtl/guard_pkg.sv
package guard_pkg;
   // cycle class as {pgm_valid, dat_valid}
   typedef enum logic [1:0] {
      CYC_INTERNAL = 2'b00,
      CYC_DATA     = 2'b01,
      CYC_PROG     = 2'b10,
      CYC_FETCH    = 2'b11
   } cyc_t;

   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2,
      ACC_EXEC  = 2'd3
   } acc_t;
endpackage

// File: rtl/guard_region.sv
module guard_region
   import guard_pkg::*;
#(
   parameter int AW    = 24,
   parameter int DW    = 32,
   parameter int SEL_W = 5,
   parameter int IDX   = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [SEL_W-1:0] cfg_sel,
   input  logic [AW-1:0]    cfg_wdata,
   input  logic [AW-1:0]    addr,
   input  acc_t             acc,
   output logic             hit,
   output logic             allow,
   output logic [DW-1:0]    rdata
);
   localparam logic [SEL_W-1:0] LO_SEL  = SEL_W'(4*IDX);
   localparam logic [SEL_W-1:0] HI_SEL  = SEL_W'(4*IDX + 1);
   localparam logic [SEL_W-1:0] CTL_SEL = SEL_W'(4*IDX + 2);

   logic [AW-1:0] lo_q, hi_q;
   logic          en_q, rd_q, wr_q, ex_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
         en_q <= 1'b0;
         rd_q <= 1'b0;
         wr_q <= 1'b0;
         ex_q <= 1'b0;
      end else if (cfg_we) begin
         if (cfg_sel == LO_SEL) lo_q <= cfg_wdata;
         if (cfg_sel == HI_SEL) hi_q <= cfg_wdata;
         if (cfg_sel == CTL_SEL) begin
            en_q <= cfg_wdata[0];
            rd_q <= cfg_wdata[1];
            wr_q <= cfg_wdata[2];
            ex_q <= cfg_wdata[3];
         end
      end
   end

   assign hit = en_q && (addr >= lo_q) && (addr <= hi_q);

   always_comb begin
      unique case (acc)
         ACC_READ:  allow = rd_q;
         ACC_WRITE: allow = wr_q;
         ACC_EXEC:  allow = ex_q;
         default:   allow = 1'b1;
      endcase
   end

   always_comb begin
      rdata = '0;
      if (cfg_sel == LO_SEL)  rdata = DW'(lo_q);
      if (cfg_sel == HI_SEL)  rdata = DW'(hi_q);
      if (cfg_sel == CTL_SEL) rdata = DW'({ex_q, wr_q, rd_q, en_q});
   end
endmodule

// File: rtl/guard_fault_log.sv
module guard_fault_log #(
   parameter int AW       = 24,
   parameter int DW       = 32,
   parameter int SEL_W    = 5,
   parameter int ADDR_IDX = 16,
   parameter int INFO_IDX = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [AW-1:0]    addr,
   input  logic             rw_n,
   input  logic             pgm_valid,
   input  logic             dat_valid,
   input  logic             cfg_we,
   input  logic [SEL_W-1:0] cfg_sel,
   input  logic             cfg_clr_bit,
   output logic [DW-1:0]    rdata
);
   localparam logic [SEL_W-1:0] A_SEL = SEL_W'(ADDR_IDX);
   localparam logic [SEL_W-1:0] I_SEL = SEL_W'(INFO_IDX);

   logic [AW-1:0] f_addr_q;
   logic [2:0]    f_kind_q;
   logic          valid_q;
   logic          clr;

   assign clr = cfg_we && (cfg_sel == I_SEL) && cfg_clr_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_addr_q <= '0;
         f_kind_q <= '0;
         valid_q  <= 1'b0;
      end else if (capture) begin
         // a new fault outranks a software clear in the same cycle
         f_addr_q <= addr;
         f_kind_q <= {rw_n, pgm_valid, dat_valid};
         valid_q  <= 1'b1;
      end else if (clr) begin
         valid_q  <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      if (cfg_sel == A_SEL) rdata = DW'(f_addr_q);
      if (cfg_sel == I_SEL) rdata = DW'({f_kind_q, valid_q});
   end

   a_r11_logged_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> valid_q);
   a_r12_clear_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !capture) |=> !valid_q);
endmodule

// File: rtl/addr_abort_guard.sv
module addr_abort_guard
   import guard_pkg::*;
#(
   parameter int ADDR_W             = 24,
   parameter int DATA_W             = 32,
   parameter int NREGIONS           = 4,
   parameter bit EMU_FALSE_RD_CHECK = 1'b0,
   localparam int NSEL  = 4*NREGIONS + 2,
   localparam int SEL_W = $clog2(NSEL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              rw_n,
   input  logic              pgm_valid,
   input  logic              dat_valid,
   input  logic              emu_mode,
   input  logic              vec_pull,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   output logic              abort_req
);
   localparam int ADDR_IDX = 4*NREGIONS;
   localparam int INFO_IDX = 4*NREGIONS + 1;

   if (NREGIONS < 1 || NREGIONS > 16) begin : g_bad_n
      $error("NREGIONS must be 1..16");
   end
   if (DATA_W <= ADDR_W) begin : g_bad_w
      $error("DATA_W must exceed ADDR_W");
   end

   logic                unused_wdata_hi;
   assign unused_wdata_hi = ^cfg_wdata[DATA_W-1:ADDR_W];

   // ---- cycle classification ----
   logic chk_false;
   if (EMU_FALSE_RD_CHECK) begin : g_false_chk
      assign chk_false = emu_mode && rw_n;
   end else begin : g_false_skip
      assign chk_false = 1'b0;
   end

   acc_t acc;
   always_comb begin
      unique case (cyc_t'({pgm_valid, dat_valid}))
         CYC_FETCH:    acc = ACC_EXEC;
         CYC_INTERNAL: acc = chk_false ? ACC_READ : ACC_NONE;
         default:      acc = rw_n ? ACC_READ : ACC_WRITE;
      endcase
   end

   // ---- windows ----
   logic [NREGIONS-1:0] hit, allow;
   logic [DATA_W-1:0]   win_rd [NREGIONS];

   for (genvar i = 0; i < NREGIONS; i++) begin : g_win
      guard_region #(
         .AW(ADDR_W), .DW(DATA_W), .SEL_W(SEL_W), .IDX(i)
      ) u_win (
         .clk       (clk),
         .rst_n     (rst_n),
         .cfg_we    (cfg_we),
         .cfg_sel   (cfg_sel),
         .cfg_wdata (cfg_wdata[ADDR_W-1:0]),
         .addr      (bus_addr),
         .acc       (acc),
         .hit       (hit[i]),
         .allow     (allow[i]),
         .rdata     (win_rd[i])
      );
   end

   // lowest index wins: scan downward so the last assignment is the lowest hit
   logic deny;
   always_comb begin
      deny = 1'b0;
      for (int i = NREGIONS-1; i >= 0; i--) begin
         if (hit[i]) deny = ~allow[i];
      end
   end

   // ---- abort pulse and mask ----
   logic fault, masked_q, fire;
   assign fault = (acc != ACC_NONE) && deny;
   assign fire  = fault && !masked_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         abort_req <= 1'b0;
         masked_q  <= 1'b0;
      end else begin
         abort_req <= fire;
         if (fire)          masked_q <= 1'b1;
         else if (vec_pull) masked_q <= 1'b0;
      end
   end

   // ---- status ----
   logic [DATA_W-1:0] log_rd;
   guard_fault_log #(
      .AW(ADDR_W), .DW(DATA_W), .SEL_W(SEL_W),
      .ADDR_IDX(ADDR_IDX), .INFO_IDX(INFO_IDX)
   ) u_log (
      .clk         (clk),
      .rst_n       (rst_n),
      .capture     (fire),
      .addr        (bus_addr),
      .rw_n        (rw_n),
      .pgm_valid   (pgm_valid),
      .dat_valid   (dat_valid),
      .cfg_we      (cfg_we),
      .cfg_sel     (cfg_sel),
      .cfg_clr_bit (cfg_wdata[0]),
      .rdata       (log_rd)
   );

   always_comb begin
      cfg_rdata = log_rd;
      for (int i = 0; i < NREGIONS; i++) cfg_rdata = cfg_rdata | win_rd[i];
   end

   // ---- assertions ----
   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      abort_req |=> !abort_req);
   a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      masked_q |=> !abort_req);
   a_r8_internal_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (!pgm_valid && !dat_valid && !(EMU_FALSE_RD_CHECK && emu_mode && rw_n)) |=> !abort_req);
   a_r6_no_hit_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == '0) |=> !abort_req);
endmodule

// File: tb/addr_abort_guard_test.sv
`timescale 1ns/1ps
module addr_abort_guard_test;
   localparam int CLK_PERIOD = 10;
   localparam int NREG = 4;
   localparam int SW = $clog2(4*NREG + 2);
   localparam int A_IDX = 4*NREG;
   localparam int I_IDX = 4*NREG + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [23:0]   bus_addr = '0;
   logic          rw_n = 1'b1, pgm_valid = 1'b0, dat_valid = 1'b0;
   logic          emu_mode = 1'b0, vec_pull = 1'b0;
   logic          cfg_we = 1'b0;
   logic [SW-1:0] cfg_sel = '0;
   logic [31:0]   cfg_wdata = '0;
   logic [31:0]   cfg_rdata;
   logic          abort_req;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   addr_abort_guard #(
      .ADDR_W(24), .DATA_W(32), .NREGIONS(NREG), .EMU_FALSE_RD_CHECK(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .rw_n(rw_n),
      .pgm_valid(pgm_valid), .dat_valid(dat_valid), .emu_mode(emu_mode),
      .vec_pull(vec_pull), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .abort_req(abort_req)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input int sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = SW'(sel); cfg_wdata = d;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic rd_reg(input int sel, output logic [31:0] d);
      @(negedge clk);
      cfg_sel = SW'(sel);
      #1 d = cfg_rdata;
   endtask

   // one access cycle then one idle cycle; returns abort seen after the access
   task automatic access(input logic [23:0] a, input logic rw, input logic p,
                         input logic dv, input logic emu, output logic got);
      @(negedge clk);
      bus_addr = a; rw_n = rw; pgm_valid = p; dat_valid = dv; emu_mode = emu;
      @(posedge clk); #1 got = abort_req;
      @(negedge clk);
      rw_n = 1'b1; pgm_valid = 1'b0; dat_valid = 1'b0; emu_mode = 1'b0;
      @(posedge clk); #1;
      check("R10 pulse ends after one cycle", 32'(abort_req), 32'd0);
   endtask

   task automatic pull_vector();
      @(negedge clk); vec_pull = 1'b1;
      @(negedge clk); vec_pull = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d; logic g;
      check("R1 abort low in reset", 32'(abort_req), 32'd0);
      rd_reg(I_IDX, d); check("R1 info zero", d, 32'd0);
      access(24'h001000, 1'b0, 1'b0, 1'b1, 1'b0, g);
      check("R1 no window enabled", 32'(g), 32'd0);
   endtask

   task automatic t_config();
      logic [31:0] d;
      wr_reg(0, 32'h001000); wr_reg(1, 32'h001FFF); wr_reg(2, 32'h3);   // read only
      wr_reg(4, 32'h002000); wr_reg(5, 32'h002FFF); wr_reg(6, 32'hF);   // all
      wr_reg(8, 32'h001800); wr_reg(9, 32'h0018FF); wr_reg(10, 32'hF);  // overlaps 0
      wr_reg(12, 32'h800000); wr_reg(13, 32'h80FFFF); wr_reg(14, 32'h0); // disabled
      rd_reg(4, d);  check("R12 lower bound readback", d, 32'h002000);
      rd_reg(5, d);  check("R12 upper bound readback", d, 32'h002FFF);
      rd_reg(2, d);  check("R12 control readback", d, 32'h3);
      rd_reg(7, d);  check("R12 spare index zero", d, 32'h0);
   endtask

   task automatic t_read();
      logic g;
      access(24'h001000, 1'b1, 1'b0, 1'b1, 1'b0, g);
      check("R5 data read at lower bound allowed", 32'(g), 32'd0);
      access(24'h001400, 1'b1, 1'b1, 1'b0, 1'b0, g);
      check("R5 program read allowed", 32'(g), 32'd0);
   endtask

   task automatic t_write_and_mask();
      logic g; logic [31:0] d;
      access(24'h001FFF, 1'b0, 1'b0, 1'b1, 1'b0, g);
      check("R4 R2 write at upper bound aborts", 32'(g), 32'd1);
      rd_reg(A_IDX, d); check("R11 fault address", d, 32'h001FFF);
      rd_reg(I_IDX, d); check("R11 fault info write", d, 32'h3);
      access(24'h001010, 1'b0, 1'b0, 1'b1, 1'b0, g);
      check("R10 masked until vector pull", 32'(g), 32'd0);
      rd_reg(A_IDX, d); check("R10 masked fault not logged", d, 32'h001FFF);
      pull_vector();
      access(24'h001010, 1'b0, 1'b0, 1'b1, 1'b0, g);
      check("R10 checks resume after vector pull", 32'(g), 32'd1);
      pull_vector();
      wr_reg(I_IDX, 32'h1);
      rd_reg(I_IDX, d); check("R12 clear valid", d[0], 32'd0);
   endtask

   task automatic t_exec();
      logic g; logic [31:0] d;
      access(24'h001100, 1'b1, 1'b1, 1'b1, 1'b0, g);
      check("R3 fetch without execute aborts", 32'(g), 32'd1);
      rd_reg(I_IDX, d); check("R11 fault info fetch", d, 32'hF);
      pull_vector();
      access(24'h002100, 1'b1, 1'b1, 1'b1, 1'b0, g);
      check("R3 fetch with execute allowed", 32'(g), 32'd0);
   endtask

   task automatic t_outside_and_overlap();
      logic g;
      access(24'h000FFF, 1'b0, 1'b0, 1'b1, 1'b0, g);
      check("R6 just below window", 32'(g), 32'd0);
      access(24'h002000, 1'b0, 1'b0, 1'b1, 1'b0, g);
      check("R6 write in open window", 32'(g), 32'd0);
      access(24'h800010, 1'b0, 1'b0, 1'b1, 1'b0, g);
      check("R6 disabled window ignored", 32'(g), 32'd0);
      access(24'h001850, 1'b0, 1'b0, 1'b1, 1'b0, g);
      check("R7 lowest window decides", 32'(g), 32'd1);
      pull_vector();
   endtask

   task automatic t_internal();
      logic g;
      wr_reg(14, 32'h1);  // window 3 enabled, no permissions
      access(24'h800020, 1'b0, 1'b0, 1'b0, 1'b1, g);
      check("R8 internal write ignored", 32'(g), 32'd0);
      access(24'h800020, 1'b1, 1'b0, 1'b0, 1'b0, g);
      check("R9 native false read ignored", 32'(g), 32'd0);
      access(24'h800020, 1'b1, 1'b0, 1'b0, 1'b1, g);
      check("R9 emulation false read checked", 32'(g), 32'd1);
      pull_vector();
      access(24'h800020, 1'b1, 1'b0, 1'b1, 1'b1, g);
      check("R5 data read without read bit", 32'(g), 32'd1);
      pull_vector();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_config();
      t_read();
      t_write_and_mask();
      t_exec();
      t_outside_and_overlap();
      t_internal();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1'b1;
         checks++; failures++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule